// File: doc/BRIEF.md
# NAND Parameter Page Validator

This block screens the parameter page that a flash device sends back after a read-parameter command. The page is sent several times in a row for redundancy, and this block picks the first copy it can trust. A controller pulses `start` once the device is ready to stream, then feeds the page bytes through a valid/ready handshake. The validator walks the copies one at a time. For each copy it counts signature byte matches and runs a seeded CRC-16 over the body. At the end of each copy it compares the CRC with the check value stored in the copy.

When a copy is accepted the block pulses `done` with `pass` high. It publishes the address-cycle byte of that copy as separate column and row cycle counts, and it stops taking bytes, so later copies stay in the stream for whoever drains it. If every copy fails, `done` pulses with `pass` low and the cycle counts keep their earlier values. Copy length, copy count, the offset of the address byte and the signature threshold are parameters.

Top module: `param_page_check`

## Requirements
- R1: The check value of a copy is a 16-bit CRC over its bytes 0 to 253, seeded with 0x4F4E. For each byte, the byte is XORed into bits 15:8. Then eight steps shift left by one, and a step XORs in 0x8005 when the bit shifted out was 1. The copy's CRC test passes only when this value equals byte 254 (low half) joined with byte 255 (high half).
- R2: The expected signature is 0x4F, 0x4E, 0x46, 0x49 in bytes 0, 1, 2, 3. A copy's signature test passes when two or more of those four positions hold the expected byte, whichever positions they are.
- R3: A copy that passes both tests is accepted. One cycle after its byte 255 is taken, `done` is high with `pass` = 1, and `in_ready` is low from that cycle on, so no byte of a later copy is taken.
- R4: A copy that fails either test is taken in full (256 bytes), and the next byte taken counts as byte 0 of the next copy.
- R5: If the third copy also fails, `done` is high with `pass` = 0 one cycle after that copy's byte 255, and exactly 768 bytes have been taken.
- R6: On acceptance, `col_cycles` takes bits 7:4 and `row_cycles` takes bits 3:0 of byte 101 of the accepted copy. Byte 101 of a rejected copy never reaches them, and after a run in which all copies fail they keep their previous values.
- R7: A byte is taken only in a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low until a `start` pulse, and bytes offered while it is low are ignored. A `start` seen while a run is in progress has no effect.
- R8: After reset `in_ready`, `done` and `pass` are 0, and `col_cycles` and `row_cycles` are 0.
- R9: `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new validation run |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Parameter page byte |
| in_ready | output | 1 | Block will take the offered byte |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run (1 = a copy was accepted) |
| col_cycles | output | 4 | Column address cycle count from the accepted copy |
| row_cycles | output | 4 | Row address cycle count from the accepted copy |

## Verification
The bench sweeps all sixteen patterns of correct signature positions in the first copy. A validator that demanded all four bytes, or took just one, would consume 512 bytes instead of 256 on some patterns, or the reverse. Other runs corrupt the first copy's CRC, swap the two CRC bytes, or give each copy a different address byte. These catch a design that accepts a bad copy, reads the check value big-endian, or latches byte 101 from a rejected copy. An all-fail run checks that the cycle counts survive untouched. The bench also sends bytes before arming and a stray `start` mid-run; a design that took those bytes or restarted would lose its 256-byte alignment and return a wrong count or verdict.

// File: rtl/ppv_pkg.sv
package ppv_pkg;
   localparam int BYTE_W = 8;
   localparam int CRC_W  = 16;
   localparam int NIB_W  = BYTE_W / 2;
   // expected signature, position 0 in the low byte
   localparam logic [4*BYTE_W-1:0] SIG_WORD = 32'h4946_4E4F;
   localparam logic [CRC_W-1:0] CRC_SEED = 16'h4F4E;
   localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

   typedef enum logic {PPV_IDLE = 1'b0, PPV_SCAN = 1'b1} ppv_state_e;
endpackage

// File: rtl/ppv_crc_step.sv
module ppv_crc_step #(
   parameter int CW = 16,
   parameter int DW = 8,
   parameter logic [CW-1:0] POLY = 16'h8005
) (
   input  logic [CW-1:0] crc_in,
   input  logic [DW-1:0] data,
   output logic [CW-1:0] crc_out
);
   logic [CW-1:0] stage [0:DW];

   assign stage[0] = crc_in ^ {data, {(CW-DW){1'b0}}};

   for (genvar k = 0; k < DW; k++) begin : g_bit
      assign stage[k+1] = stage[k][CW-1] ? ((stage[k] << 1) ^ POLY)
                                         : (stage[k] << 1);
   end

   assign crc_out = stage[DW];
endmodule

// File: rtl/ppv_sig_match.sv
module ppv_sig_match #(
   parameter int DW    = 8,
   parameter int NSIG  = 4,
   parameter int IW    = 8,
   parameter logic [NSIG*DW-1:0] SIG = 32'h4946_4E4F
) (
   input  logic [IW-1:0] idx,
   input  logic [DW-1:0] data,
   output logic          hit
);
   logic [NSIG-1:0] pos_hit;

   for (genvar p = 0; p < NSIG; p++) begin : g_pos
      assign pos_hit[p] = (idx == IW'(p)) && (data == SIG[p*DW +: DW]);
   end

   assign hit = |pos_hit;
endmodule

// File: rtl/param_page_check.sv
module param_page_check #(
   parameter int PAGE_BYTES  = 256,
   parameter int MAX_COPIES  = 3,
   parameter int ACYC_OFFSET = 101,
   parameter int SIG_MIN     = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output logic       in_ready,
   output logic       done,
   output logic       pass,
   output logic [3:0] col_cycles,
   output logic [3:0] row_cycles
);
   import ppv_pkg::*;

   localparam int IDX_W   = $clog2(PAGE_BYTES);
   localparam int CP_W    = (MAX_COPIES > 1) ? $clog2(MAX_COPIES) : 1;
   localparam int CRC_LEN = PAGE_BYTES - 2;
   localparam int NSIG    = 4;
   localparam int SC_W    = $clog2(NSIG + 1);
   localparam logic [IDX_W-1:0] IDX_CLO  = IDX_W'(CRC_LEN);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(PAGE_BYTES - 1);
   localparam logic [IDX_W-1:0] IDX_ACYC = IDX_W'(ACYC_OFFSET);
   localparam logic [CP_W-1:0]  CP_LAST  = CP_W'(MAX_COPIES - 1);

   if (PAGE_BYTES < 8 || (1 << IDX_W) != PAGE_BYTES) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if (ACYC_OFFSET < NSIG || ACYC_OFFSET >= CRC_LEN) begin : g_chk_acyc
      $error("ACYC_OFFSET must sit inside the CRC-covered body");
   end
   if (MAX_COPIES < 1) begin : g_chk_cp
      $error("MAX_COPIES must be at least 1");
   end
   if (SIG_MIN < 1 || SIG_MIN > NSIG) begin : g_chk_sig
      $error("SIG_MIN must be between 1 and 4");
   end

   ppv_state_e           state;
   logic [IDX_W-1:0]     idx;
   logic [CP_W-1:0]      copy_idx;
   logic [CRC_W-1:0]     crc_q;
   logic [CRC_W-1:0]     crc_nxt;
   logic [SC_W-1:0]      sig_cnt;
   logic [BYTE_W-1:0]    acyc_q;
   logic [BYTE_W-1:0]    crc_lo_q;
   logic                 sig_hit;
   logic                 take;
   logic                 copy_ok;
   logic                 done_q;
   logic                 pass_q;
   logic [NIB_W-1:0]     col_q;
   logic [NIB_W-1:0]     row_q;

   ppv_crc_step #(.CW(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY)) u_crc (
      .crc_in  (crc_q),
      .data    (in_data),
      .crc_out (crc_nxt)
   );

   ppv_sig_match #(.DW(BYTE_W), .NSIG(NSIG), .IW(IDX_W), .SIG(SIG_WORD)) u_sig (
      .idx  (idx),
      .data (in_data),
      .hit  (sig_hit)
   );

   assign in_ready = (state == PPV_SCAN);
   assign take     = in_ready && in_valid;
   assign copy_ok  = (sig_cnt >= SC_W'(SIG_MIN)) && (crc_q == {in_data, crc_lo_q});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= PPV_IDLE;
         idx      <= '0;
         copy_idx <= '0;
         crc_q    <= CRC_SEED;
         sig_cnt  <= '0;
         acyc_q   <= '0;
         crc_lo_q <= '0;
         done_q   <= 1'b0;
         pass_q   <= 1'b0;
         col_q    <= '0;
         row_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (state == PPV_IDLE) begin
            if (start) begin
               state    <= PPV_SCAN;
               idx      <= '0;
               copy_idx <= '0;
               crc_q    <= CRC_SEED;
               sig_cnt  <= '0;
            end
         end else if (take) begin
            if (sig_hit)         sig_cnt  <= sig_cnt + 1'b1;
            if (idx < IDX_CLO)   crc_q    <= crc_nxt;
            if (idx == IDX_ACYC) acyc_q   <= in_data;
            if (idx == IDX_CLO)  crc_lo_q <= in_data;
            if (idx == IDX_LAST) begin
               if (copy_ok) begin
                  state  <= PPV_IDLE;
                  done_q <= 1'b1;
                  pass_q <= 1'b1;
                  col_q  <= acyc_q[BYTE_W-1:NIB_W];
                  row_q  <= acyc_q[NIB_W-1:0];
               end else if (copy_idx == CP_LAST) begin
                  state  <= PPV_IDLE;
                  done_q <= 1'b1;
                  pass_q <= 1'b0;
               end else begin
                  copy_idx <= copy_idx + 1'b1;
                  idx      <= '0;
                  crc_q    <= CRC_SEED;
                  sig_cnt  <= '0;
               end
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   assign done       = done_q;
   assign pass       = pass_q;
   assign col_cycles = col_q;
   assign row_cycles = row_q;
endmodule

// File: rtl/ppv_checker.sv
module ppv_checker #(
   parameter int MAX_COPIES = 3,
   parameter int CP_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            in_ready,
   input logic            done,
   input logic            pass,
   input logic [3:0]      col_cycles,
   input logic [3:0]      row_cycles,
   input logic [CP_W-1:0] copy_idx
);
   // R9: done lasts a single cycle
   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: nothing more is taken once a run has ended
   a_r3_ready_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !in_ready);

   // R3: the verdict only moves when a run ends
   a_r3_pass_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pass) |-> done);

   // R6: cycle counts only move on an accepted copy
   a_r6_fields_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({col_cycles, row_cycles}) |-> (done && pass));

   // R7: a start while idle opens the byte window
   a_r7_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !in_ready) |=> in_ready);

   // R5: the copy counter never passes the last copy
   a_r5_copy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      copy_idx <= CP_W'(MAX_COPIES - 1));
endmodule

bind param_page_check ppv_checker #(
   .MAX_COPIES (MAX_COPIES),
   .CP_W       (CP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .in_ready   (in_ready),
   .done       (done),
   .pass       (pass),
   .col_cycles (col_cycles),
   .row_cycles (row_cycles),
   .copy_idx   (copy_idx)
);

// File: tb/param_page_check_tb.sv
module param_page_check_tb;
   localparam int PB = 256;
   localparam int NC = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_ready, done, pass;
   logic [3:0] col_cycles, row_cycles;

   int n_checks = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [7:0] stream_b [0:PB*NC-1];
   int         c_mask [0:NC-1];
   int         c_mode [0:NC-1];
   logic [7:0] c_acyc [0:NC-1];
   logic [3:0] exp_col = 4'h0;
   logic [3:0] exp_row = 4'h0;

   param_page_check u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_data(in_data), .in_ready(in_ready), .done(done), .pass(pass),
      .col_cycles(col_cycles), .row_cycles(row_cycles)
   );

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int base);
      logic [15:0] c = 16'h4F4E;
      for (int i = 0; i < PB - 2; i++) begin
         c = c ^ {stream_b[base + i], 8'h00};
         for (int b = 0; b < 8; b++)
            c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
      end
      return c;
   endfunction

   // mode: 0 correct check value, 1 corrupted, 2 byte-swapped
   task automatic build_stream();
      logic [31:0] sig = 32'h4946_4E4F;
      logic [15:0] c;
      for (int k = 0; k < NC; k++) begin
         for (int i = 0; i < PB; i++)
            stream_b[k*PB + i] = 8'((k*7 + i*13 + 5) & 8'hFF);
         for (int p = 0; p < 4; p++)
            stream_b[k*PB + p] = c_mask[k][p] ? sig[p*8 +: 8] : (sig[p*8 +: 8] ^ 8'h20);
         stream_b[k*PB + 101] = c_acyc[k];
         c = ref_crc(k*PB);
         if (c[7:0] == c[15:8]) begin
            stream_b[k*PB + 100] = stream_b[k*PB + 100] ^ 8'h01;
            c = ref_crc(k*PB);
         end
         case (c_mode[k])
            0: begin stream_b[k*PB+254] = c[7:0];  stream_b[k*PB+255] = c[15:8]; end
            1: begin stream_b[k*PB+254] = c[7:0] ^ 8'h01; stream_b[k*PB+255] = c[15:8]; end
            default: begin stream_b[k*PB+254] = c[15:8]; stream_b[k*PB+255] = c[7:0]; end
         endcase
      end
   endtask

   task automatic run_case(input string tag, input bit mid_start);
      int consumed = 0;
      int guard = 0;
      bit got = 0;
      int exp_cons = PB*NC;
      int exp_pass = 0;
      int gp = 0;
      int gc = 0;
      int gr = 0;
      build_stream();
      for (int k = NC - 1; k >= 0; k--) begin
         if ($countones(c_mask[k][3:0]) >= 2 && c_mode[k] == 0) begin
            exp_cons = (k + 1) * PB;
            exp_pass = 1;
            exp_col = c_acyc[k][7:4];
            exp_row = c_acyc[k][3:0];
         end
      end
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (!got && guard < 4000) begin
         if (done) begin
            got = 1;
            gp = int'(pass); gc = int'(col_cycles); gr = int'(row_cycles);
            in_valid = 1'b0; start = 1'b0;
         end else begin
            in_valid = ((guard % 29) != 7) && (consumed < PB*NC);
            in_data = stream_b[(consumed < PB*NC) ? consumed : 0];
            start = mid_start && (consumed == 100);
            if (in_valid && in_ready) consumed++;
            @(negedge clk);
         end
         guard++;
      end
      check({tag, " R3 R4 R5 done seen"}, int'(got), 1);
      check({tag, " R3 R4 R5 bytes taken"}, consumed, exp_cons);
      check({tag, " R1 R2 R5 verdict"}, gp, exp_pass);
      check({tag, " R6 col_cycles"}, gc, int'(exp_col));
      check({tag, " R6 row_cycles"}, gr, int'(exp_row));
      @(negedge clk);
      check({tag, " R9 done one cycle"}, int'(done), 0);
      check({tag, " R3 ready low after"}, int'(in_ready), 0);
   endtask

   task automatic set_copy(input int k, input int m, input int md, input logic [7:0] a);
      c_mask[k] = m; c_mode[k] = md; c_acyc[k] = a;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 in_ready", int'(in_ready), 0);
      check("R8 done", int'(done), 0);
      check("R8 pass", int'(pass), 0);
      check("R8 col_cycles", int'(col_cycles), 0);
      check("R8 row_cycles", int'(row_cycles), 0);
      rst_n = 1'b1;

      // R7: bytes offered before arming are ignored
      begin
         int bad = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'(i * 3);
            if (in_ready || done) bad++;
         end
         in_valid = 1'b0;
         check("R7 idle ignores bytes", bad, 0);
      end

      // R2 sweep over signature match patterns in copy 0
      for (int m = 0; m < 16; m++) begin
         set_copy(0, m, 0, 8'((m * 17) ^ 8'h21));
         set_copy(1, 15, 0, 8'h52);
         set_copy(2, 15, 0, 8'h13);
         run_case($sformatf("sig mask %0d", m), 1'b0);
      end

      // R6 address byte nibble split
      foreach (c_acyc[j]) c_acyc[j] = 8'h00;
      begin
         logic [7:0] vals [0:3] = '{8'h00, 8'hFF, 8'h4A, 8'hA4};
         for (int v = 0; v < 4; v++) begin
            set_copy(0, 15, 0, vals[v]);
            set_copy(1, 15, 0, 8'h11);
            set_copy(2, 15, 0, 8'h11);
            run_case($sformatf("R6 acyc %0h", vals[v]), 1'b0);
         end
      end

      // R1 corrupted CRC first, R2 bad signature second, third good
      set_copy(0, 15, 1, 8'h77);
      set_copy(1, 1, 0, 8'h66);
      set_copy(2, 3, 0, 8'h35);
      run_case("R1 R4 third copy", 1'b0);

      // R5 all fail: fields keep 3/5
      set_copy(0, 15, 1, 8'h99);
      set_copy(1, 8, 0, 8'h88);
      set_copy(2, 15, 1, 8'hEE);
      run_case("R5 all fail", 1'b0);

      // R1 byte order of the stored check value
      set_copy(0, 15, 2, 8'h12);
      set_copy(1, 15, 2, 8'h12);
      set_copy(2, 15, 2, 8'h12);
      run_case("R1 swapped crc", 1'b0);

      // R7 start during a run has no effect
      set_copy(0, 6, 1, 8'hC1);
      set_copy(1, 12, 0, 8'h24);
      set_copy(2, 15, 0, 8'h11);
      run_case("R7 mid start", 1'b1);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule